// File: doc/BRIEF.md
# Multi-Rail Power Sequencer Controller

This controller brings up three regulator channels: two step-down channels and one step-up/down channel. It does this by driving one enable per channel, in a fixed order that is gated by each channel's power-good. A master power-on input starts the work. A per-channel enable input lets unused channels drop out of the chain, and the chain carries on past them without waiting. If every channel enable is low when power-on rises, the controller waits a fixed initialization time. After that it hands each channel enable straight to its input, so the system can raise the rails in any order or all at once.

The controller also drives an active-low processor reset. The reset is released only after every running channel has shown power-good for a programmable number of cycles. A loss of regulation pulls the reset low but leaves the rails on while power-on is held. A global fault removes everything: overtemperature or input undervoltage turns off the channels, the always-on rail and the auxiliary output. When power-on is still high as the fault clears, the default sequence runs again. Power-good and fault inputs are resynchronized with two flops. Both time spans are counted in clock cycles.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst` is high, `rail_en_o`, `aux_en_o` and `rst_n_o` are 0 and `aon_en_o` is 1.
- R2: Bit 0 of the channel vectors is step-down 1, bit 1 is step-down 2 and bit 2 is step-up/down. On a rising `pwr_on_i` with at least one `chan_en_i` bit high, only the lowest enabled channel is switched on, at the next clock edge, and at most one sequenced channel turns on per cycle.
- R3: A later channel is switched on only after the synchronized power-good of the channel before it in the chain is high.
- R4: A channel whose `chan_en_i` bit is low is skipped. The next enabled channel is switched on directly after the previous one regulates, and a skipped channel is never turned on.
- R5: If all `chan_en_i` bits are low when `pwr_on_i` rises, no rail is turned on for `INIT_CYC` cycles. After that, `rail_en_o` follows `chan_en_i` one cycle late, in any order.
- R6: `rst_n_o` goes high only after all switched-on channels have shown synchronized power-good for `RST_CYC` cycles in the run or manual phase. Loss of power-good on a switched-on channel drives it low at the next edge.
- R7: During a loss of regulation with `pwr_on_i` high, `rail_en_o` is unchanged. After power-good returns, `rst_n_o` stays low for a full `RST_CYC` delay again.
- R8: A synchronized overtemperature or undervoltage fault turns off all `rail_en_o` bits, `aon_en_o` and `aux_en_o`, and drives `rst_n_o` low at the next edge.
- R9: When a global fault clears with `pwr_on_i` still high, the default sequence restarts from the lowest enabled channel.
- R10: `pwr_on_i` low turns off all rails at the next edge. Rails come back only after a new rising edge of `pwr_on_i`, even when a fault clears while it is low.
- R11: `aon_en_o` depends only on the global faults. `aux_en_o` is high in every phase except off and fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_i | input | 1 | Master power-on request |
| chan_en_i | input | 3 | Per-channel enable (bit 0 step-down 1, bit 1 step-down 2, bit 2 step-up/down) |
| pgood_i | input | 3 | Per-channel power-good, asynchronous |
| ovt_fault_i | input | 1 | Overtemperature fault, asynchronous |
| uv_fault_i | input | 1 | Input undervoltage fault, asynchronous |
| rail_en_o | output | 3 | Channel enables |
| aon_en_o | output | 1 | Always-on rail enable |
| aux_en_o | output | 1 | Auxiliary output enable |
| rst_n_o | output | 1 | Active-low processor reset |

## Verification
The sequencing is tried with all eight enable patterns at power-on. The first rail that turns on shows whether the order is fixed and whether disabled channels are skipped. The final rail set shows that a skipped channel never turns on. The all-low pattern tells manual mode apart from sequencing. Power-good is then released one channel at a time, which separates gating on power-good from free running. Further runs cover a regulation dip while power-on is held, a global fault that clears with power-on high and one that clears with power-on low, and enables changed during the initialization wait. Together these separate holding the rails, restarting the sequence and staying off.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int NCH = 3;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_INIT   = 3'd1,
    ST_SEQ1   = 3'd2,
    ST_SEQ2   = 3'd3,
    ST_SEQ3   = 3'd4,
    ST_RUN    = 3'd5,
    ST_MANUAL = 3'd6,
    ST_FAULT  = 3'd7
  } seq_state_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pwr_timer.sv
module pwr_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = (cnt_q == LIM);

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int RST_CYC  = 2000,
  parameter int INIT_CYC = 1000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pwr_on_i,
  input  logic [NCH-1:0] chan_en_i,
  input  logic [NCH-1:0] pgood_i,
  input  logic           ovt_fault_i,
  input  logic           uv_fault_i,
  output logic [NCH-1:0] rail_en_o,
  output logic           aon_en_o,
  output logic           aux_en_o,
  output logic           rst_n_o
);
  localparam int SW = NCH + 2;
  localparam logic [NCH-1:0] ONE = NCH'(1);

  logic [SW-1:0]  sync_q;
  logic [NCH-1:0] pgood_s;
  logic           gfault_s;
  seq_state_e     state_q, state_d, start_st;
  logic [NCH-1:0] mask_q, mask_d, rail_en_q, rail_d;
  logic [1:0]     cur_idx;
  logic           pwr_on_q, rise;
  logic           init_done, rst_done, reg_ok, rel_d;
  logic           aon_q, aux_q, rst_n_q;

  pwr_sync #(.W(SW)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ovt_fault_i, uv_fault_i, pgood_i}),
    .q_o (sync_q)
  );

  assign pgood_s  = sync_q[NCH-1:0];
  assign gfault_s = |sync_q[SW-1:NCH];

  pwr_timer #(.LIMIT(INIT_CYC)) u_init_tmr (
    .clk    (clk),
    .rst    (rst),
    .run_i  (state_q == ST_INIT),
    .done_o (init_done)
  );

  pwr_timer #(.LIMIT(RST_CYC)) u_rst_tmr (
    .clk    (clk),
    .rst    (rst),
    .run_i  (reg_ok),
    .done_o (rst_done)
  );

  function automatic seq_state_e stage_of(input logic [1:0] k);
    case (k)
      2'd0:    return ST_SEQ1;
      2'd1:    return ST_SEQ2;
      default: return ST_SEQ3;
    endcase
  endfunction

  function automatic logic [1:0] idx_of(input seq_state_e s);
    case (s)
      ST_SEQ1: return 2'd0;
      ST_SEQ2: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // lowest enabled channel at or above 'from', else the run phase
  function automatic seq_state_e pick_stage(input logic [NCH-1:0] en, input int from);
    seq_state_e r;
    r = ST_RUN;
    for (int j = NCH - 1; j >= 0; j--) begin
      if (j >= from && en[j]) r = stage_of(2'(j));
    end
    return r;
  endfunction

  assign rise    = pwr_on_i & ~pwr_on_q;
  assign cur_idx = idx_of(state_q);

  always_comb begin
    start_st = (|chan_en_i) ? pick_stage(chan_en_i, 0) : ST_INIT;
    state_d  = state_q;
    case (state_q)
      ST_OFF:   if (rise) state_d = gfault_s ? ST_FAULT : start_st;
      ST_INIT:  if (init_done) state_d = ST_MANUAL;
      ST_SEQ1, ST_SEQ2, ST_SEQ3: begin
        if (!chan_en_i[cur_idx] || pgood_s[cur_idx])
          state_d = pick_stage(chan_en_i, int'(cur_idx) + 1);
      end
      ST_FAULT: if (!gfault_s) state_d = start_st;
      default:  state_d = state_q;
    endcase
    if (state_q != ST_OFF) begin
      if (!pwr_on_i)     state_d = ST_OFF;
      else if (gfault_s) state_d = ST_FAULT;
    end
  end

  always_comb begin
    case (state_d)
      ST_SEQ1, ST_SEQ2, ST_SEQ3: mask_d = mask_q | (ONE << idx_of(state_d));
      ST_RUN:                    mask_d = mask_q;
      default:                   mask_d = '0;
    endcase
    rail_d = (state_d == ST_MANUAL) ? chan_en_i : mask_d;
  end

  assign reg_ok = ((state_q == ST_RUN) || (state_q == ST_MANUAL)) &&
                  (&(pgood_s | ~rail_en_q));
  assign rel_d  = ((state_d == ST_RUN) || (state_d == ST_MANUAL)) && reg_ok && rst_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OFF;
      mask_q    <= '0;
      rail_en_q <= '0;
      pwr_on_q  <= 1'b0;
      aon_q     <= 1'b1;
      aux_q     <= 1'b0;
      rst_n_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      mask_q    <= mask_d;
      rail_en_q <= rail_d;
      pwr_on_q  <= pwr_on_i;
      aon_q     <= ~gfault_s;
      aux_q     <= (state_d != ST_OFF) && (state_d != ST_FAULT);
      rst_n_q   <= rel_d;
    end
  end

  assign rail_en_o = rail_en_q;
  assign aon_en_o  = aon_q;
  assign aux_en_o  = aux_q;
  assign rst_n_o   = rst_n_q;

  // R2
  one_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_MANUAL) |-> $onehot0(rail_en_o & ~$past(rail_en_o)));

  // R6
  reg_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (|(rail_en_o & ~pgood_s)) |=> !rst_n_o);

  // R7
  rails_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && pwr_on_i && !gfault_s) |=> (rail_en_o == $past(rail_en_o)));

  // R8
  gfault_off_chk: assert property (@(posedge clk) disable iff (rst)
    gfault_s |=> (rail_en_o == '0 && !aon_en_o && !aux_en_o && !rst_n_o));

  // R10
  pwr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_on_i |=> (rail_en_o == '0));
endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RST_N = 12;
  localparam int INIT_N = 5;
  localparam int WD_CYC = 100000;

  // {chan_en, first rail expected after power-on with power-good low}
  localparam logic [5:0] SEQ_VEC [8] = '{
    {3'b000, 3'b000}, {3'b001, 3'b001}, {3'b010, 3'b010}, {3'b011, 3'b001},
    {3'b100, 3'b100}, {3'b101, 3'b001}, {3'b110, 3'b010}, {3'b111, 3'b001}
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       pwr_on;
  logic [2:0] chan_en;
  logic [2:0] pgood;
  logic       ovt, uv;
  logic [2:0] rail_en;
  logic       aon_en, aux_en, rst_n;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwr_seq_ctrl #(.RST_CYC(RST_N), .INIT_CYC(INIT_N)) i_pwr_seq_ctrl (
    .clk         (clk),
    .rst         (rst),
    .pwr_on_i    (pwr_on),
    .chan_en_i   (chan_en),
    .pgood_i     (pgood),
    .ovt_fault_i (ovt),
    .uv_fault_i  (uv),
    .rail_en_o   (rail_en),
    .aon_en_o    (aon_en),
    .aux_en_o    (aux_en),
    .rst_n_o     (rst_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; pwr_on = 1'b0; chan_en = 3'b000; pgood = 3'b000; ovt = 1'b0; uv = 1'b0;
    tick(3);
    // R1 reset state
    check("R1 rails", int'(rail_en), 0);
    check("R1 aux", int'(aux_en), 0);
    check("R1 reset out", int'(rst_n), 0);
    check("R1 aon", int'(aon_en), 1);
    rst = 1'b0;
    tick(2);

    // table walk over all enable patterns
    for (int v = 0; v < 8; v++) begin
      pwr_on = 1'b0; pgood = 3'b000;
      tick(3);
      chan_en = SEQ_VEC[v][5:3];
      pwr_on = 1'b1;
      tick(4);
      check($sformatf("R2 first rail en=%b", SEQ_VEC[v][5:3]), int'(rail_en), int'(SEQ_VEC[v][2:0]));
      pgood = 3'b111;
      tick(10);
      check($sformatf("R4 final rails en=%b", SEQ_VEC[v][5:3]), int'(rail_en), int'(SEQ_VEC[v][5:3]));
      tick(RST_N + 6);
      check($sformatf("R6 reset released en=%b", SEQ_VEC[v][5:3]), int'(rst_n), 1);
    end

    // R3: power-good gating one channel at a time
    pwr_on = 1'b0; pgood = 3'b000; tick(3);
    chan_en = 3'b111; pwr_on = 1'b1;
    tick(8);
    check("R3 waits on pgood0", int'(rail_en), 3'b001);
    pgood = 3'b001; tick(6);
    check("R3 step after pgood0", int'(rail_en), 3'b011);
    check("R6 low while sequencing", int'(rst_n), 0);
    pgood = 3'b011; tick(6);
    check("R3 step after pgood1", int'(rail_en), 3'b111);

    // R4: skip middle channel
    pwr_on = 1'b0; pgood = 3'b000; tick(3);
    chan_en = 3'b101; pwr_on = 1'b1;
    tick(4);
    pgood = 3'b001; tick(6);
    check("R4 skip channel 1", int'(rail_en), 3'b101);

    // R7 / R6: regulation dip with power-on held
    pgood = 3'b111; chan_en = 3'b111;
    pwr_on = 1'b0; tick(3); pwr_on = 1'b1;
    tick(10 + RST_N + 6);
    check("R6 released in run", int'(rst_n), 1);
    check("R11 aux on in run", int'(aux_en), 1);
    pgood = 3'b101; tick(4);
    check("R6 reset on pgood loss", int'(rst_n), 0);
    check("R7 rails held", int'(rail_en), 3'b111);
    pgood = 3'b111; tick(RST_N);
    check("R7 full delay again", int'(rst_n), 0);
    tick(6);
    check("R7 released after delay", int'(rst_n), 1);

    // R8 / R9: undervoltage fault, cleared with power-on high
    uv = 1'b1; tick(4);
    check("R8 rails off", int'(rail_en), 0);
    check("R8 aon off", int'(aon_en), 0);
    check("R8 aux off", int'(aux_en), 0);
    check("R8 reset low", int'(rst_n), 0);
    pgood = 3'b000; tick(6);
    uv = 1'b0; tick(5);
    check("R9 resequence first", int'(rail_en), 3'b001);
    check("R11 aon back", int'(aon_en), 1);
    pgood = 3'b111; tick(8);
    check("R9 resequence done", int'(rail_en), 3'b111);

    // R10: power-on drop and no restart without new edge
    pwr_on = 1'b0; tick(1);
    check("R10 rails off next edge", int'(rail_en), 0);
    pwr_on = 1'b1; tick(6);
    ovt = 1'b1; pgood = 3'b000; tick(4);
    pwr_on = 1'b0; tick(2);
    ovt = 1'b0; tick(8);
    check("R10 stays off", int'(rail_en), 0);
    check("R11 aux off in off", int'(aux_en), 0);
    check("R11 aon only faults", int'(aon_en), 1);
    pwr_on = 1'b1; tick(3);
    check("R10 new edge restarts", int'(rail_en), 3'b001);

    // R5: manual mode, enables changed during the wait
    pwr_on = 1'b0; pgood = 3'b000; chan_en = 3'b000; tick(3);
    pwr_on = 1'b1; tick(2);
    chan_en = 3'b010; tick(1);
    check("R5 no rail during wait", int'(rail_en), 0);
    tick(INIT_N + 4);
    check("R5 follows enable", int'(rail_en), 3'b010);
    chan_en = 3'b111; tick(2);
    check("R5 all at once", int'(rail_en), 3'b111);
    chan_en = 3'b100; tick(2);
    check("R5 any order", int'(rail_en), 3'b100);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule